// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Engine

This block is the host end of a single-wire debug link, working one bit at a time. It runs on its own clock, which has no phase relation to the target's clock. All of its timing comes from a programmable ratio of host cycles per target cycle. The host starts every bit, including bits that travel from the target to the host.

For an outgoing bit, the engine pulls the line low. It then drives the bit level actively, so the wire never has to rise through a slow pull-up. For an incoming bit, it gives a short low start pulse and then lets go of the line. It samples the line late in the bit, through a two-flop synchronizer, and returns the value with a one-cycle completion strobe.

A higher layer issues one request per bit and waits for the strobe before issuing the next. That higher layer handles byte serialisation and command sequencing.

Top module: `sdw_host_bit`

## Requirements
- R1: After reset and whenever idle, ready_o=1, done_o=0 and line_drive_o=0 (line released). rbit_o resets to 0.
- R2: A request is taken only in a cycle where ready_o=1 and req_i=1. From the next cycle, ready_o stays 0 for exactly 16*R host cycles, where R is the effective ratio. req_i is ignored while ready_o=0.
- R3: dir_i=1 selects a host-to-target bit. When wbit_i=0, line_drive_o=1 for the whole bit. line_level_o=0 for the first 13*R cycles and 1 for the remaining cycles.
- R4: For a host-to-target bit with wbit_i=1, line_drive_o=1 for the whole bit. line_level_o=0 for the first 4*R cycles and 1 afterwards.
- R5: dir_i=0 selects a target-to-host bit. The line is driven low (line_drive_o=1, line_level_o=0) for the first 2*R cycles and released (line_drive_o=0) for the rest of the bit. It is never driven high.
- R6: The received bit equals the value of line_i in host cycle 10*R of the bit, where cycle 0 is the first cycle with ready_o=0. The sample passes through a two-flop synchronizer, and the capture is delayed by the synchronizer latency to make up for it.
- R7: done_o is a one-cycle pulse in the first idle cycle after a bit. rbit_o changes only together with done_o. It takes the received value after a target-to-host bit and keeps its old value after a host-to-target bit.
- R8: ratio_i is taken in the accepting cycle. Changes to ratio_i while a bit is in progress have no effect on that bit's timing.
- R9: ratio_i=0 is treated as R=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | RATIO_W | Host cycles per target cycle (0 means 1) |
| req_i | input | 1 | Start a bit |
| dir_i | input | 1 | 1 = host to target, 0 = target to host |
| wbit_i | input | 1 | Bit value to send |
| ready_o | output | 1 | Idle, request accepted |
| done_o | output | 1 | One-cycle bit-complete strobe |
| rbit_o | output | 1 | Last received bit |
| line_drive_o | output | 1 | Output enable for the line pad |
| line_level_o | output | 1 | Level driven when enabled |
| line_i | input | 1 | Line level seen at the pad (asynchronous) |

## Verification
The bound checker watches four things on every cycle:
- the line is released while idle;
- done_o is a single pulse that coincides with the return to idle;
- rbit_o changes only with done_o;
- each bit lasts exactly 16 target cycles at the ratio latched at acceptance, and a target-to-host bit never drives the line high.

Only the bench scenarios can show the following:
- the exact low-pulse widths for each bit value and direction;
- that the sampled value comes from host cycle 10*R and no other cycle, which the bench shows with one-cycle glitches on line_i;
- that requests and ratio changes during a bit are ignored.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } sdw_state_e;

  // bit timing in target cycles
  localparam int unsigned SDW_BIT_T      = 16;
  localparam int unsigned SDW_TX0_LOW_T  = 13;
  localparam int unsigned SDW_TX1_LOW_T  = 4;
  localparam int unsigned SDW_RX_LOW_T   = 2;
  localparam int unsigned SDW_RX_SMP_T   = 10;
  localparam int unsigned SDW_SYNC_N     = 2;
endpackage

// File: rtl/sdw_sync.sv
module sdw_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= RST_VAL;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_chain
      logic [STAGES-1:0] q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= {STAGES{RST_VAL}};
        else         q_q <= {q_q[STAGES-2:0], d_i};
      end
      assign q_o = q_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sdw_timebase.sv
module sdw_timebase #(
  parameter int unsigned RATIO_W  = 8,
  parameter int unsigned BIT_T    = 16,
  parameter int unsigned RX_SMP_T = 10,
  localparam int unsigned TC_W    = $clog2(BIT_T)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [TC_W-1:0]    tc_o,
  output logic               last_o,
  output logic               smp_o
);
  logic [RATIO_W-1:0] pc_q;
  logic [TC_W-1:0]    tc_q;
  logic               tc_end;

  assign tc_end = (pc_q == ratio_i - RATIO_W'(1));
  assign last_o = run_i && tc_end && (tc_q == TC_W'(BIT_T - 1));
  assign smp_o  = run_i && (pc_q == '0) && (tc_q == TC_W'(RX_SMP_T));
  assign tc_o   = tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (!run_i || last_o) begin
      pc_q <= '0;
      tc_q <= '0;
    end else if (tc_end) begin
      pc_q <= '0;
      tc_q <= tc_q + TC_W'(1);
    end else begin
      pc_q <= pc_q + RATIO_W'(1);
    end
  end
endmodule

// File: rtl/sdw_shaper.sv
module sdw_shaper #(
  parameter int unsigned BIT_T     = 16,
  parameter int unsigned TX0_LOW_T = 13,
  parameter int unsigned TX1_LOW_T = 4,
  parameter int unsigned RX_LOW_T  = 2,
  localparam int unsigned TC_W     = $clog2(BIT_T)
) (
  input  logic            busy_i,
  input  logic            send_i,
  input  logic            wbit_i,
  input  logic [TC_W-1:0] tc_i,
  output logic            drive_o,
  output logic            level_o
);
  logic [TC_W-1:0] low_end;

  always_comb begin
    if (!send_i)     low_end = TC_W'(RX_LOW_T);
    else if (wbit_i) low_end = TC_W'(TX1_LOW_T);
    else             low_end = TC_W'(TX0_LOW_T);
  end

  // send: active drive whole bit; receive: low start pulse then release
  assign drive_o = busy_i && (send_i || (tc_i < low_end));
  assign level_o = busy_i && send_i && (tc_i >= low_end);
endmodule

// File: rtl/sdw_host_bit.sv
module sdw_host_bit
  import sdw_pkg::*;
#(
  parameter int unsigned RATIO_W   = 8,
  parameter int unsigned SYNC_N    = SDW_SYNC_N,
  parameter int unsigned BIT_T     = SDW_BIT_T,
  parameter int unsigned TX0_LOW_T = SDW_TX0_LOW_T,
  parameter int unsigned TX1_LOW_T = SDW_TX1_LOW_T,
  parameter int unsigned RX_LOW_T  = SDW_RX_LOW_T,
  parameter int unsigned RX_SMP_T  = SDW_RX_SMP_T
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               req_i,
  input  logic               dir_i,
  input  logic               wbit_i,
  output logic               ready_o,
  output logic               done_o,
  output logic               rbit_o,
  output logic               line_drive_o,
  output logic               line_level_o,
  input  logic               line_i
);
  localparam int unsigned TC_W = $clog2(BIT_T);

  sdw_state_e         st_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               send_q, wbit_q;
  logic               done_q, rbit_q, smp_q;
  logic [SYNC_N-1:0]  smp_sr;
  logic               busy, accept, last, smp_str, line_s;
  logic [TC_W-1:0]    tc;

  assign busy   = (st_q == ST_BUSY);
  assign accept = !busy && req_i;

  sdw_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  sdw_timebase #(.RATIO_W(RATIO_W), .BIT_T(BIT_T), .RX_SMP_T(RX_SMP_T)) i_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .ratio_i(ratio_q),
    .tc_o   (tc),
    .last_o (last),
    .smp_o  (smp_str)
  );

  sdw_shaper #(
    .BIT_T(BIT_T), .TX0_LOW_T(TX0_LOW_T), .TX1_LOW_T(TX1_LOW_T), .RX_LOW_T(RX_LOW_T)
  ) i_shaper (
    .busy_i (busy),
    .send_i (send_q),
    .wbit_i (wbit_q),
    .tc_i   (tc),
    .drive_o(line_drive_o),
    .level_o(line_level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ratio_q <= RATIO_W'(1);
      send_q  <= 1'b0;
      wbit_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= busy && last;
      if (!busy) ratio_q <= (ratio_i == '0) ? RATIO_W'(1) : ratio_i;
      if (accept) begin
        st_q   <= ST_BUSY;
        send_q <= dir_i;
        wbit_q <= wbit_i;
      end else if (busy && last) begin
        st_q <= ST_IDLE;
      end
    end
  end

  // delay the sample strobe by the synchronizer depth
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_sr <= '0;
      smp_q  <= 1'b0;
      rbit_q <= 1'b0;
    end else begin
      smp_sr <= (smp_sr << 1) | SYNC_N'(smp_str);
      if (smp_sr[SYNC_N-1]) smp_q <= line_s;
      if (busy && last && !send_q) rbit_q <= smp_q;
    end
  end

  assign ready_o = !busy;
  assign done_o  = done_q;
  assign rbit_o  = rbit_q;
endmodule

// File: rtl/sdw_host_bit_chk.sv
module sdw_host_bit_chk #(
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned BIT_T   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               req_i,
  input logic               dir_i,
  input logic               ready_o,
  input logic               done_o,
  input logic               rbit_o,
  input logic               line_drive_o,
  input logic               line_level_o
);
  localparam int unsigned CW = RATIO_W + $clog2(BIT_T) + 1;

  logic [CW-1:0]      cnt_q;
  logic [RATIO_W-1:0] r_q;
  logic               send_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      r_q    <= RATIO_W'(1);
      send_q <= 1'b0;
    end else if (ready_o && req_i) begin
      cnt_q  <= '0;
      r_q    <= (ratio_i == '0) ? RATIO_W'(1) : ratio_i;
      send_q <= dir_i;
    end else if (!ready_o) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assert_idle_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !line_drive_o);
  assert_bit_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (cnt_q == CW'(BIT_T) * CW'(r_q)));
  assert_rx_no_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !send_q && line_drive_o) |-> !line_level_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_at_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> done_o);
  assert_rbit_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rbit_o));
endmodule

bind sdw_host_bit sdw_host_bit_chk #(.RATIO_W(RATIO_W), .BIT_T(BIT_T)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ratio_i     (ratio_i),
  .req_i       (req_i),
  .dir_i       (dir_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .rbit_o      (rbit_o),
  .line_drive_o(line_drive_o),
  .line_level_o(line_level_o)
);

// File: tb/test_sdw_host_bit.sv
`timescale 1ns/1ps
module test_sdw_host_bit;
  localparam int unsigned RATIO_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RATIO_W-1:0] ratio_i = 8'd1;
  logic req_i = 1'b0, dir_i = 1'b0, wbit_i = 1'b0;
  logic line_i = 1'b1;
  logic ready_o, done_o, rbit_o, line_drive_o, line_level_o;

  int n_chk = 0;
  int n_err = 0;
  logic exp_rbit = 1'b0;

  always #2.5 clk = ~clk;

  sdw_host_bit #(.RATIO_W(RATIO_W)) i_sdw_host_bit (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio_i), .req_i(req_i),
    .dir_i(dir_i), .wbit_i(wbit_i), .ready_o(ready_o), .done_o(done_o),
    .rbit_o(rbit_o), .line_drive_o(line_drive_o), .line_level_o(line_level_o),
    .line_i(line_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one bit; rx_pat: 0 -> target glitches low only at cycle 10R, 1 -> high only there
  task automatic run_bit(input bit send, input bit wbit, input int r_set, input int r,
                         input bit rx_pat, input bit poke, input string req);
    int bad_drv = 0, bad_lvl = 0, bad_rdy = 0;
    bit tgt;
    @(negedge clk);
    check(ready_o == 1'b1, "R2", "ready before request", int'(ready_o), 1);
    ratio_i = RATIO_W'(r_set);
    dir_i = send; wbit_i = wbit; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    for (int hc = 0; hc < 16 * r; hc++) begin
      int low_t;
      bit e_drv, e_lvl;
      low_t = send ? (wbit ? 4 : 13) : 2;
      e_drv = send ? 1'b1 : (hc < low_t * r);
      e_lvl = send ? (hc >= low_t * r) : 1'b0;
      if (ready_o !== 1'b0) bad_rdy++;
      if (line_drive_o !== e_drv) bad_drv++;
      if (e_drv && line_level_o !== e_lvl) bad_lvl++;
      tgt = (hc == 10 * r) ? rx_pat : ~rx_pat;
      line_i = line_drive_o ? line_level_o : tgt;
      if (poke) begin
        req_i = (hc >= 3 && hc < 16 * r - 1);
        ratio_i = RATIO_W'(r_set + 7);
      end
      @(negedge clk);
    end
    req_i = 1'b0; line_i = 1'b1; ratio_i = RATIO_W'(r_set);
    if (!send) exp_rbit = rx_pat;
    check(bad_rdy == 0, "R2", "busy cycles with ready high", bad_rdy, 0);
    check(bad_drv == 0, req, "drive enable mismatches", bad_drv, 0);
    check(bad_lvl == 0, req, "drive level mismatches", bad_lvl, 0);
    check(ready_o == 1'b1, "R2", "ready after 16R cycles", int'(ready_o), 1);
    check(done_o == 1'b1, "R7", "done after bit", int'(done_o), 1);
    check(rbit_o == exp_rbit, send ? "R7" : "R6", "rbit", int'(rbit_o), int'(exp_rbit));
    @(negedge clk);
    check(done_o == 1'b0, "R7", "done one cycle", int'(done_o), 0);
    check(ready_o == 1'b1 && line_drive_o == 1'b0, "R1", "idle and released",
          int'(line_drive_o), 0);
    check(rbit_o == exp_rbit, "R7", "rbit held", int'(rbit_o), int'(exp_rbit));
  endtask

  task automatic t_reset();
    #1;
    check(ready_o == 1'b1, "R1", "ready in reset", int'(ready_o), 1);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    check(line_drive_o == 1'b0, "R1", "drive in reset", int'(line_drive_o), 0);
    check(rbit_o == 1'b0, "R1", "rbit in reset", int'(rbit_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ready_o == 1'b1 && line_drive_o == 1'b0, "R1", "idle after reset",
          int'(line_drive_o), 0);
  endtask

  task automatic t_send0();  run_bit(1'b1, 1'b0, 1, 1, 1'b0, 1'b0, "R3"); endtask
  task automatic t_send0_r3(); run_bit(1'b1, 1'b0, 3, 3, 1'b0, 1'b0, "R3"); endtask
  task automatic t_send1();  run_bit(1'b1, 1'b1, 3, 3, 1'b0, 1'b0, "R4"); endtask
  task automatic t_recv0();  run_bit(1'b0, 1'b0, 2, 2, 1'b0, 1'b0, "R5"); endtask
  task automatic t_recv1();  run_bit(1'b0, 1'b0, 5, 5, 1'b1, 1'b0, "R5"); endtask
  task automatic t_send_keeps_rbit(); run_bit(1'b1, 1'b0, 2, 2, 1'b0, 1'b0, "R3"); endtask
  // R8: request and ratio changes mid-bit are ignored
  task automatic t_poke();   run_bit(1'b1, 1'b1, 4, 4, 1'b0, 1'b1, "R8"); endtask
  task automatic t_poke_rx(); run_bit(1'b0, 1'b0, 3, 3, 1'b0, 1'b1, "R8"); endtask
  // R9: ratio 0 acts as 1
  task automatic t_ratio0(); run_bit(1'b0, 1'b0, 0, 1, 1'b1, 1'b0, "R9"); endtask
  task automatic t_ratio0_tx(); run_bit(1'b1, 1'b1, 0, 1, 1'b0, 1'b0, "R9"); endtask

  initial begin
    t_reset();
    t_send0();
    t_send0_r3();
    t_send1();
    t_recv1();
    t_recv0();
    t_recv1();
    t_send_keeps_rbit();
    t_poke();
    t_poke_rx();
    t_ratio0();
    t_ratio0_tx();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule